// File: doc/BRIEF.md
# Rewindable FIFO with Tiered Occupancy Flags

This block is a single-clock first-in first-out buffer for 9-bit words. Its depth is a power of two, set by a parameter. Writes and reads are requested on separate inputs. Addresses come only from an internal write pointer and an internal read pointer. Three status outputs grade the fill level: empty, more than half full, and full.

Read data is presented combinationally. It comes out together with a valid qualifier, and that qualifier takes the place of an output bus that would otherwise float. A read request held while the buffer is empty stays parked. The first word written afterwards then falls through to the output. A rewind input moves the read pointer back to physical location zero, so the block written since reset can be played out again.

The operating mode is captured while reset is held. In solo mode, the half-full grade and the rewind are available. In chained mode, both are disabled. The block also detects a rewind requested after the write pointer has started reusing locations. It refuses that rewind and reports it on an error output.

Top module: `retx_fifo`

## Requirements
- R1: While `rst_n` is low at a clock edge, both pointers return to location zero. After release, `empty`=1, `half_full`=0, `full`=0 and `rd_valid`=0, and no word written before the reset can be read.
- R2: With n unread words and DEPTH locations, the flags are as follows. `empty`=1 only when n=0. `full`=1 only when n=DEPTH. `half_full`=1 in solo mode exactly when n>DEPTH/2, so it is also 1 whenever `full` is 1.
- R3: A write request while `full`=1 is dropped. A read request while `empty`=1 returns `rd_valid`=0. Neither request moves a pointer, which shows in the flags and in the order of later reads.
- R4: Words leave in the order they were accepted. In a cycle with an accepted read, `rd_valid`=1 and `rd_data` holds the oldest unread word. The pointer advances at the next clock edge.
- R5: When read and write are requested in the same cycle with 0<n<DEPTH, both take effect and n does not change.
- R6: In solo mode, with no more than DEPTH writes since reset, `rewind`=1 with `rd_req`=0 and `wr_req`=0 sets the read pointer to location zero. From the next cycle the flags reflect n equal to the writes since reset. Reads then restart from the first word written, and this can be repeated.
- R7: `rewind` has no effect in any cycle in which `rd_req` or `wr_req` is 1.
- R8: `exp_in` is sampled at clock edges while `rst_n` is low. `exp_in`=0 selects solo mode and `exp_in`=1 selects chained mode. In chained mode `half_full` stays 0, and `rewind` neither moves the read pointer nor raises `rewind_err`. Changes of `exp_in` after release have no effect.
- R9: A read request that sees `empty`=1 stays parked while `rd_req` is held. The cycle after the next accepted write, that word appears with `rd_valid`=1 and is consumed. Later words are not delivered until `rd_req` has gone to 0 and returned to 1.
- R10: `rd_valid` is 0 in every cycle in which `rd_req` is 0 or `empty` is 1.
- R11: Once more than DEPTH writes have been accepted since reset, an idle solo-mode `rewind` raises `rewind_err` in the same cycle and leaves the read pointer where it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| exp_in | input | 1 | Mode select sampled during reset: 0 solo, 1 chained |
| wr_req | input | 1 | Write request, one word per cycle |
| wr_data | input | WIDTH | Word to store |
| rd_req | input | 1 | Read request |
| rewind | input | 1 | Move the read pointer back to location zero |
| rd_data | output | WIDTH | Oldest unread word, meaningful when rd_valid is 1 |
| rd_valid | output | 1 | A read is accepted this cycle |
| empty | output | 1 | No unread words |
| half_full | output | 1 | More than half the locations hold unread words (solo mode) |
| full | output | 1 | Every location holds an unread word |
| rewind_err | output | 1 | Rewind refused because locations have been reused |

## Verification
A wrong pointer value shows up in two places. The flags are wrong in the very next cycle, because they decode straight from the pointer difference. The data word returned on the next accepted read is also wrong. So a sweep over every fill level, from zero to DEPTH, exposes an off-by-one within one cycle of the bad edge. A faulty parked-read or spent state shows as `rd_valid` asserting one cycle too early, one cycle too late, or twice during a held request. A wrong reuse tracker shows as `rewind_err` at the wrong write count, or as a rewind that restarts the read order when it should be refused.

// File: rtl/retx_fifo_pkg.sv
package retx_fifo_pkg;

  typedef enum logic {
    MODE_SOLO  = 1'b0,
    MODE_CHAIN = 1'b1
  } fifo_mode_e;

  typedef struct packed {
    logic empty;
    logic half;
    logic full;
  } tier_t;

  // Grade a fill count against the capacity.
  function automatic tier_t tier_of(input int unsigned fill,
                                    input int unsigned depth,
                                    input logic solo);
    tier_t t;
    t.empty = (fill == 0);
    t.full  = (fill == depth);
    t.half  = solo && (fill > (depth / 2));
    return t;
  endfunction

endpackage

// File: rtl/retx_fifo_ram.sv
module retx_fifo_ram #(
  parameter int WIDTH = 9,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/retx_fifo_ptrs.sv
module retx_fifo_ptrs #(
  parameter int AW = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_fire,
  input  logic        rd_fire,
  input  logic        rewind_go,
  output logic [AW:0] wr_ptr,
  output logic [AW:0] rd_ptr,
  output logic        reused
);
  localparam int PW = AW + 1;

  logic lap_q;

  // Step a pointer by one word; the top bit is the lap bit.
  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      lap_q  <= 1'b0;
      reused <= 1'b0;
    end else begin
      if (wr_fire) begin
        wr_ptr <= bump(wr_ptr);
        if (wr_ptr[AW-1:0] == {AW{1'b1}}) lap_q <= 1'b1;
        if (lap_q) reused <= 1'b1;
      end
      if (rewind_go)    rd_ptr <= '0;
      else if (rd_fire) rd_ptr <= bump(rd_ptr);
    end
  end
endmodule

// File: rtl/retx_fifo_tiers.sv
module retx_fifo_tiers #(
  parameter int AW = 4
) (
  input  logic [AW:0] wr_ptr,
  input  logic [AW:0] rd_ptr,
  input  logic        solo,
  output logic [AW:0] fill,
  output logic        empty,
  output logic        half_full,
  output logic        full
);
  import retx_fifo_pkg::*;

  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  function automatic logic [PW-1:0] fill_of(input logic [PW-1:0] w,
                                            input logic [PW-1:0] r);
    return w - r;
  endfunction

  tier_t t;

  always_comb begin
    fill      = fill_of(wr_ptr, rd_ptr);
    t         = tier_of(32'(fill), DEPTH, solo);
    empty     = t.empty;
    half_full = t.half;
    full      = t.full;
  end
endmodule

// File: rtl/retx_fifo_rdgate.sv
module retx_fifo_rdgate (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_req,
  input  logic empty,
  output logic rd_fire,
  output logic parked,
  output logic spent
);
  // parked: request held through an empty cycle, still unserved.
  // spent:  a parked request was served; hold off until rd_req drops.
  assign rd_fire = rd_req && !empty && !spent;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      parked <= 1'b0;
      spent  <= 1'b0;
    end else begin
      parked <= rd_req && empty && !spent;
      spent  <= rd_req && (spent || (rd_fire && parked));
    end
  end
endmodule

// File: rtl/retx_fifo.sv
module retx_fifo #(
  parameter int WIDTH      = 9,
  parameter int DEPTH_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exp_in,
  input  logic             wr_req,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_req,
  input  logic             rewind,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  output logic             empty,
  output logic             half_full,
  output logic             full,
  output logic             rewind_err
);
  import retx_fifo_pkg::*;

  localparam int AW = DEPTH_LOG2;
  localparam int PW = AW + 1;

  fifo_mode_e    mode_q;
  logic          solo;
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;
  logic [PW-1:0] fill;
  logic          reused;
  logic          wr_fire;
  logic          rd_fire;
  logic          parked;
  logic          spent;
  logic          idle;
  logic          rewind_go;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= exp_in ? MODE_CHAIN : MODE_SOLO;
  end

  assign solo       = (mode_q == MODE_SOLO);
  assign idle       = !rd_req && !wr_req;
  assign wr_fire    = wr_req && !full;
  assign rewind_go  = rewind && idle && solo && !reused;
  assign rewind_err = rewind && idle && solo && reused;
  assign rd_valid   = rd_fire;

  retx_fifo_ptrs #(.AW(AW)) u_ptrs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_fire  (wr_fire),
    .rd_fire  (rd_fire),
    .rewind_go(rewind_go),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .reused   (reused)
  );

  retx_fifo_tiers #(.AW(AW)) u_tiers (
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .solo     (solo),
    .fill     (fill),
    .empty    (empty),
    .half_full(half_full),
    .full     (full)
  );

  retx_fifo_rdgate u_rdgate (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_req (rd_req),
    .empty  (empty),
    .rd_fire(rd_fire),
    .parked (parked),
    .spent  (spent)
  );

  retx_fifo_ram #(.WIDTH(WIDTH), .AW(AW)) u_ram (
    .clk  (clk),
    .we   (wr_fire),
    .waddr(wr_ptr[AW-1:0]),
    .wdata(wr_data),
    .raddr(rd_ptr[AW-1:0]),
    .rdata(rd_data)
  );
endmodule

// File: rtl/retx_fifo_chk.sv
module retx_fifo_chk #(
  parameter int PW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_req,
  input logic          rd_req,
  input logic          rewind,
  input logic          empty,
  input logic          half_full,
  input logic          full,
  input logic          rd_valid,
  input logic          rewind_err,
  input logic          solo,
  input logic [PW-1:0] wr_ptr,
  input logic [PW-1:0] rd_ptr,
  input logic          rewind_go,
  input logic          spent
);
  logic [PW-1:0] fill_now;
  assign fill_now = wr_ptr - rd_ptr;

  assert_reset_flags_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (empty && !half_full && !full));

  assert_full_implies_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (full && solo) |-> half_full);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_req && !rd_req) |=> full);

  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !wr_req && !rewind) |=> empty);

  assert_pair_keeps_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && wr_req && !full) |=> $stable(fill_now));

  assert_rewind_to_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rewind_go |=> (rd_ptr == '0));

  assert_busy_rewind_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rewind && !rd_req && wr_req) |=> $stable(rd_ptr));

  assert_chain_no_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !solo |-> (!half_full && !rewind_err));

  assert_spent_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    spent |-> !rd_valid);

  assert_valid_needs_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_req && !empty));

  assert_refused_rewind_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rewind_err |=> $stable(rd_ptr));
endmodule

bind retx_fifo retx_fifo_chk #(.PW(PW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_req    (wr_req),
  .rd_req    (rd_req),
  .rewind    (rewind),
  .empty     (empty),
  .half_full (half_full),
  .full      (full),
  .rd_valid  (rd_valid),
  .rewind_err(rewind_err),
  .solo      (solo),
  .wr_ptr    (wr_ptr),
  .rd_ptr    (rd_ptr),
  .rewind_go (rewind_go),
  .spent     (spent)
);

// File: tb/sim_retx_fifo.sv
`timescale 1ns/100ps
module sim_retx_fifo;
  localparam int W  = 9;
  localparam int AW = 3;
  localparam int D  = 1 << AW;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         exp_in = 1'b0;
  logic         wr_req = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         rd_req = 1'b0;
  logic         rewind = 1'b0;
  logic [W-1:0] rd_data;
  logic         rd_valid, empty, half_full, full, rewind_err;

  always #2.5 clk = ~clk;

  retx_fifo #(.WIDTH(W), .DEPTH_LOG2(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .exp_in(exp_in), .wr_req(wr_req),
    .wr_data(wr_data), .rd_req(rd_req), .rewind(rewind),
    .rd_data(rd_data), .rd_valid(rd_valid), .empty(empty),
    .half_full(half_full), .full(full), .rewind_err(rewind_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // Reference model: absolute word counts since reset.
  int           m_wr, m_rd;
  logic [W-1:0] m_mem [D];
  bit           m_solo, m_wait, m_done;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_flags(input string tag);
    int n;
    n = m_wr - m_rd;
    chk(empty == (n == 0), tag, "empty", empty, int'(n == 0));
    chk(full == (n == D), tag, "full", full, int'(n == D));
    chk(half_full == (m_solo && 2 * n > D), tag, "half_full", half_full,
        int'(m_solo && 2 * n > D));
  endtask

  task automatic do_reset(input logic chained);
    rst_n = 1'b0; exp_in = chained;
    wr_req = 1'b0; rd_req = 1'b0; rewind = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    exp_in = ~chained;
    m_wr = 0; m_rd = 0; m_solo = !chained; m_wait = 0; m_done = 0;
    #1;
    check_flags("R1");
    chk(rd_valid == 1'b0, "R1", "rd_valid", rd_valid, 0);
  endtask

  // One clock: drive, check combinational outputs, clock, check flags.
  task automatic cyc(input logic rr, input logic ww, input logic [W-1:0] d,
                     input logic rw, input string tag);
    bit exp_v, exp_err, take_w, rew_ok;
    int n;
    rd_req = rr; wr_req = ww; wr_data = d; rewind = rw;
    #1;
    n       = m_wr - m_rd;
    exp_v   = rr && n > 0 && !m_done;
    exp_err = rw && !rr && !ww && m_solo && m_wr > D;
    rew_ok  = rw && !rr && !ww && m_solo && m_wr <= D;
    take_w  = ww && n < D;
    chk(rd_valid == exp_v, tag, "rd_valid", rd_valid, exp_v);
    if (exp_v)
      chk(rd_data == m_mem[m_rd % D], tag, "rd_data", rd_data, m_mem[m_rd % D]);
    chk(rewind_err == exp_err, tag, "rewind_err", rewind_err, exp_err);
    @(posedge clk);
    m_done = rr && (m_done || (exp_v && m_wait));
    m_wait = rr && n == 0 && !(m_done && !exp_v);
    if (exp_v) m_wait = 1'b0;
    if (take_w) begin m_mem[m_wr % D] = d; m_wr++; end
    if (exp_v) m_rd++;
    if (rew_ok) m_rd = 0;
    @(negedge clk);
    check_flags(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    @(negedge clk);
    do_reset(1'b0);

    // R1: contents are gone after reset
    for (int i = 0; i < 3; i++) cyc(0, 1, W'(40 + i), 0, "R1");
    do_reset(1'b0);
    cyc(1, 0, '0, 0, "R1");
    cyc(0, 0, '0, 0, "R1");

    // R2/R3/R4: every fill level in solo mode
    for (int k = 0; k <= D; k++) begin
      do_reset(1'b0);
      for (int i = 0; i < k; i++) cyc(0, 1, W'(k * 17 + i), 0, "R2");
      if (k == D) cyc(0, 1, 9'h1ff, 0, "R3");
      for (int i = 0; i < k; i++) cyc(1, 0, '0, 0, "R4");
      cyc(1, 0, '0, 0, "R3");
      cyc(0, 0, '0, 0, "R10");
    end

    // R8: chained mode, no half grade, rewind inert
    for (int k = D / 2 + 1; k <= D; k++) begin
      do_reset(1'b1);
      for (int i = 0; i < k; i++) cyc(0, 1, W'(200 + i), 0, "R8");
      cyc(0, 0, '0, 1, "R8");
      for (int i = 0; i < k; i++) cyc(1, 0, '0, 0, "R8");
      cyc(0, 0, '0, 1, "R8");
    end

    // R5: simultaneous read and write
    do_reset(1'b0);
    for (int i = 0; i < 4; i++) cyc(0, 1, W'(60 + i), 0, "R5");
    for (int i = 0; i < 10; i++) cyc(1, 1, W'(70 + i), 0, "R5");
    cyc(0, 0, '0, 0, "R10");

    // R9: flow-through with a held read
    do_reset(1'b0);
    cyc(1, 0, '0, 0, "R9");
    cyc(1, 1, 9'h0a5, 0, "R9");
    cyc(1, 1, 9'h15a, 0, "R9");
    cyc(1, 0, '0, 0, "R9");
    cyc(0, 0, '0, 0, "R9");
    cyc(1, 0, '0, 0, "R9");
    cyc(0, 0, '0, 0, "R9");

    // R6/R7: rewind and replay
    do_reset(1'b0);
    for (int i = 0; i < 5; i++) cyc(0, 1, W'(100 + i), 0, "R6");
    for (int i = 0; i < 3; i++) cyc(1, 0, '0, 0, "R6");
    cyc(0, 0, '0, 1, "R6");
    for (int i = 0; i < 5; i++) cyc(1, 0, '0, 0, "R6");
    cyc(0, 0, '0, 1, "R6");
    for (int i = 0; i < 2; i++) cyc(1, 0, '0, 0, "R6");
    cyc(1, 0, '0, 1, "R7");
    cyc(0, 1, 9'h0c3, 1, "R7");
    cyc(1, 0, '0, 0, "R7");
    cyc(0, 0, '0, 0, "R10");

    // R11: rewind refused once a location is reused
    do_reset(1'b0);
    for (int i = 0; i < D; i++) cyc(0, 1, W'(300 + i), 0, "R11");
    for (int i = 0; i < 3; i++) cyc(1, 0, '0, 0, "R11");
    cyc(0, 0, '0, 1, "R11");
    for (int i = 0; i < 2; i++) cyc(1, 0, '0, 0, "R11");
    for (int i = 0; i < 2; i++) cyc(0, 1, W'(320 + i), 0, "R11");
    cyc(0, 0, '0, 1, "R11");
    for (int i = 0; i < 3; i++) cyc(1, 0, '0, 0, "R11");

    // R4: pseudo-random traffic, write-heavy then read-heavy
    do_reset(1'b0);
    lf = 16'hace1;
    for (int i = 0; i < 3000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (i < 1500) cyc(lf[0], lf[1] | lf[2], lf[11:3], 0, "R4");
      else          cyc(lf[0] | lf[1], lf[2], lf[11:3], 0, "R4");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule